// File: doc/BRIEF.md
# Host Bridge Request Translator

This block sits between a processor-side memory-mapped request bus and the downstream side of a host bridge. Each incoming read or write is sorted into one of three classes. It may hit the configuration aperture, where the address offset names a bus, device, function and register. It may hit one of the programmed outbound memory windows. Or it may be unclaimed. Configuration hits leave the block as configuration requests. Window hits leave on a memory port with the processor's own address. Unclaimed requests are answered with an error and produce no downstream traffic.

Configuration completions come back as a status code plus data. The block shapes them into the processor response. A configuration read that fails on the root bus yields a value of all ones rather than an error, so enumeration software can probe empty slots safely. Only one request is in flight at any time.

Top module: `hbx_bridge_xlate`

## Requirements
- R1: A request accepted with `req_valid` high while `req_ready` is high, whose address lies in the configuration aperture, produces a one-cycle `cfg_valid` pulse in the cycle after acceptance. `cfg_write` equals the request's `req_write`, and `fwd_wdata` equals its write data.
- R2: The aperture is the 256 MiB block whose address bits [31:28] equal `ecam_sel`. Within it, the offset decodes as bus = bits [27:20], device = bits [19:15], function = bits [14:12] and register byte offset = bits [11:0]. The aperture takes precedence over any memory window.
- R3: A request outside the aperture is forwarded on the memory port when, for some window i with `win_en[i]` = 1, `base_i <= addr <= limit_i`. Both ends are inclusive. Window i occupies bits [32*i+31:32*i] of `win_base` and `win_limit`. A window with `win_en[i]` = 0 claims nothing.
- R4: A forwarded memory request pulses `mem_valid` for one cycle after acceptance. `mem_addr` is exactly the processor address, `mem_write` carries the same direction, and `fwd_wdata` carries the write data.
- R5: A request that hits neither the aperture nor an enabled window pulses `rsp_valid` in the cycle after acceptance, with `rsp_err` = 1 and `rsp_rdata` = 0. No `cfg_valid` or `mem_valid` pulse is issued for it.
- R6: Completion status codes are: 2'b00 success, 2'b01 unsupported request, 2'b10 no such device or function, 2'b11 other failure. A configuration read to bus `ROOT_BUS` (default 0) that completes with 2'b10 returns `rsp_rdata` = all ones with `rsp_err` = 0.
- R7: A configuration read to bus `ROOT_BUS` that completes with 2'b01 returns all ones with `rsp_err` = 0.
- R8: A configuration read to any other bus that completes with a non-success status returns all ones with `rsp_err` = 1. A configuration write that completes with a non-success status returns `rsp_err` = 1.
- R9: A successful configuration read returns `cfg_rdata` with `rsp_err` = 0. A memory completion returns `mem_err` as `rsp_err`, and returns `mem_rdata` for reads or 0 for writes. Each response appears in the cycle after the completion strobe.
- R10: `req_ready` is low from the cycle after a forwarded request is accepted until the cycle in which its response is presented. `rsp_valid` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecam_sel | input | 4 | Upper address bits selecting the configuration aperture |
| win_base | input | 96 | Packed base addresses of the outbound windows |
| win_limit | input | 96 | Packed inclusive limit addresses of the outbound windows |
| win_en | input | 3 | Per-window enable |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Processor address |
| req_wdata | input | 32 | Processor write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Response carries an error |
| rsp_rdata | output | 32 | Response read data |
| cfg_valid | output | 1 | Configuration request strobe |
| cfg_write | output | 1 | Configuration direction |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 12 | Register byte offset |
| cfg_done | input | 1 | Configuration completion strobe |
| cfg_status | input | 2 | Configuration completion status |
| cfg_rdata | input | 32 | Configuration completion data |
| mem_valid | output | 1 | Memory request strobe |
| mem_write | output | 1 | Memory direction |
| mem_addr | output | 32 | Forwarded address |
| fwd_wdata | output | 32 | Write data for either downstream port |
| mem_done | input | 1 | Memory completion strobe |
| mem_err | input | 1 | Memory completion error |
| mem_rdata | input | 32 | Memory completion data |

## Verification
Assertions check several properties on every cycle. The two downstream strobes never fire together. Each strobe follows an acceptance and carries that request's direction and address. The bridge never reports ready while a request is in flight. Every failed configuration read is answered with all ones. The decoding itself can only be shown by the bench's directed scenarios. These cover the field positions, the inclusive window edges, the effect of a disabled window, aperture precedence, and the difference between root-bus and non-root-bus failures.

// File: rtl/hbx_pkg.sv
// Shared widths and types for the host bridge request translator.
// Assumes a 32-bit processor address and a full 256-bus configuration aperture.
package hbx_pkg;
    localparam int BUS_W       = 8;
    localparam int DEV_W       = 5;
    localparam int FN_W        = 3;
    localparam int REG_W       = 12;
    localparam int ECAM_SPAN_W = BUS_W + DEV_W + FN_W + REG_W;

    typedef enum logic [1:0] {
        CPL_OK    = 2'b00,
        CPL_UR    = 2'b01,
        CPL_NODEV = 2'b10,
        CPL_OTHER = 2'b11
    } cpl_status_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_CFG  = 2'b01,
        ST_MEM  = 2'b10
    } xlate_state_e;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] regno;
    } cfg_target_t;
endpackage

// File: rtl/hbx_ecam_decode.sv
// Decides whether an address falls in the configuration aperture and
// splits its offset into bus/device/function/register fields.
// Assumes the aperture is naturally aligned to its own size.
module hbx_ecam_decode
    import hbx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [ADDR_W-ECAM_SPAN_W-1:0] ecam_sel,
    output logic                          hit,
    output cfg_target_t                   tgt
);
    // Compare the upper bits and reinterpret the offset as fields.
    always_comb begin
        hit = (addr[ADDR_W-1:ECAM_SPAN_W] == ecam_sel);
        tgt = cfg_target_t'(addr[ECAM_SPAN_W-1:0]);
    end
endmodule

// File: rtl/hbx_window_match.sv
// Tests an address against a set of inclusive base/limit windows.
// Assumes base <= limit for every enabled window; disabled windows never match.
module hbx_window_match #(
    parameter int ADDR_W  = 32,
    parameter int NUM_WIN = 3
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_WIN*ADDR_W-1:0] win_base,
    input  logic [NUM_WIN*ADDR_W-1:0] win_limit,
    input  logic [NUM_WIN-1:0]        win_en,
    output logic                      hit
);
    logic [NUM_WIN-1:0] hit_vec;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        // One comparator pair per window.
        always_comb begin
            hit_vec[i] = win_en[i]
                      && (addr >= win_base[i*ADDR_W +: ADDR_W])
                      && (addr <= win_limit[i*ADDR_W +: ADDR_W]);
        end
    end

    // Any enabled window claims the address.
    always_comb hit = |hit_vec;
endmodule

// File: rtl/hbx_cpl_shape.sv
// Turns a configuration completion into response data and error flag.
// Failed reads give all ones; on the root bus they are not reported as errors.
module hbx_cpl_shape
    import hbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              is_read,
    input  logic              on_root,
    input  cpl_status_e       status,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    // Apply the all-ones substitution and error rules.
    always_comb begin
        if (status == CPL_OK) begin
            rdata = is_read ? data : '0;
            err   = 1'b0;
        end else if (is_read) begin
            rdata = '1;
            err   = !on_root;
        end else begin
            rdata = '0;
            err   = 1'b1;
        end
    end
endmodule

// File: rtl/hbx_bridge_xlate.sv
// Top of the host bridge request translator. Classifies each processor
// request as configuration, outbound memory or unclaimed; issues one
// downstream request at a time and returns a single-cycle response.
// Assumes completions arrive no earlier than the cycle the strobe is seen.
module hbx_bridge_xlate
    import hbx_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              DATA_W   = 32,
    parameter int              NUM_WIN  = 3,
    parameter logic [BUS_W-1:0] ROOT_BUS = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-ECAM_SPAN_W-1:0] ecam_sel,
    input  logic [NUM_WIN*ADDR_W-1:0]     win_base,
    input  logic [NUM_WIN*ADDR_W-1:0]     win_limit,
    input  logic [NUM_WIN-1:0]            win_en,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          rsp_valid,
    output logic                          rsp_err,
    output logic [DATA_W-1:0]             rsp_rdata,
    output logic                          cfg_valid,
    output logic                          cfg_write,
    output logic [BUS_W-1:0]              cfg_bus,
    output logic [DEV_W-1:0]              cfg_dev,
    output logic [FN_W-1:0]               cfg_fn,
    output logic [REG_W-1:0]              cfg_reg,
    input  logic                          cfg_done,
    input  logic [1:0]                    cfg_status,
    input  logic [DATA_W-1:0]             cfg_rdata,
    output logic                          mem_valid,
    output logic                          mem_write,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [DATA_W-1:0]             fwd_wdata,
    input  logic                          mem_done,
    input  logic                          mem_err,
    input  logic [DATA_W-1:0]             mem_rdata
);
    xlate_state_e      state;
    logic              ecam_hit;
    logic              win_hit;
    cfg_target_t       dec_tgt;
    cfg_target_t       tgt_q;
    logic              fwd_write;
    logic              pend_read;
    logic              pend_root;
    logic [DATA_W-1:0] shp_rdata;
    logic              shp_err;
    cpl_status_e       cpl_stat;
    logic              accept;

    hbx_ecam_decode #(.ADDR_W(ADDR_W)) u_ecam (
        .addr     (req_addr),
        .ecam_sel (ecam_sel),
        .hit      (ecam_hit),
        .tgt      (dec_tgt)
    );

    hbx_window_match #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_win (
        .addr      (req_addr),
        .win_base  (win_base),
        .win_limit (win_limit),
        .win_en    (win_en),
        .hit       (win_hit)
    );

    // Cast the raw status bits into the completion enum.
    always_comb cpl_stat = cpl_status_e'(cfg_status);

    hbx_cpl_shape #(.DATA_W(DATA_W)) u_shape (
        .is_read (pend_read),
        .on_root (pend_root),
        .status  (cpl_stat),
        .data    (cfg_rdata),
        .rdata   (shp_rdata),
        .err     (shp_err)
    );

    // Ready only when nothing is in flight.
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_valid && req_ready;
    end

    // Drive the configuration target fields from the captured request.
    always_comb begin
        cfg_bus   = tgt_q.bus;
        cfg_dev   = tgt_q.dev;
        cfg_fn    = tgt_q.fn;
        cfg_reg   = tgt_q.regno;
        cfg_write = fwd_write;
        mem_write = fwd_write;
    end

    // Request sequencing: capture, forward, wait for completion, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cfg_valid <= 1'b0;
            mem_valid <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            tgt_q     <= '0;
            fwd_write <= 1'b0;
            fwd_wdata <= '0;
            mem_addr  <= '0;
            pend_read <= 1'b0;
            pend_root <= 1'b0;
        end else begin
            cfg_valid <= 1'b0;
            mem_valid <= 1'b0;
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        pend_read <= !req_write;
                        fwd_write <= req_write;
                        fwd_wdata <= req_wdata;
                        if (ecam_hit) begin
                            cfg_valid <= 1'b1;
                            tgt_q     <= dec_tgt;
                            pend_root <= (dec_tgt.bus == ROOT_BUS);
                            state     <= ST_CFG;
                        end else if (win_hit) begin
                            mem_valid <= 1'b1;
                            mem_addr  <= req_addr;
                            state     <= ST_MEM;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_rdata <= '0;
                        end
                    end
                end
                ST_CFG: begin
                    if (cfg_done) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= shp_err;
                        rsp_rdata <= shp_rdata;
                        state     <= ST_IDLE;
                    end
                end
                ST_MEM: begin
                    if (mem_done) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= mem_err;
                        rsp_rdata <= pend_read ? mem_rdata : '0;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Configuration strobe follows an aperture hit with the same direction.
    assert_cfg_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> ($past(accept && ecam_hit) && cfg_write == $past(req_write)));

    // Aperture wins over windows: never two downstream strobes at once.
    assert_one_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && mem_valid));

    // Forwarded address is the untranslated processor address.
    assert_no_xlate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($past(win_hit) && mem_addr == $past(req_addr)));

    // Failed configuration reads always answer with all ones.
    assert_fail_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == ST_CFG && cfg_done && pend_read && cfg_status != 2'b00)
        |-> (rsp_valid && rsp_rdata == '1));

    // Root-bus failed reads are not errors.
    assert_root_noerr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == ST_CFG && cfg_done && pend_read && pend_root) |-> !rsp_err);

    // No new request is taken while one is in flight.
    assert_single_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid || mem_valid) |-> !req_ready);
endmodule

// File: tb/test_hbx_bridge_xlate.sv
module test_hbx_bridge_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ecam_sel = 4'h3;
    logic [95:0] win_base;
    logic [95:0] win_limit;
    logic [2:0]  win_en = 3'b111;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        cfg_valid, cfg_write;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [11:0] cfg_reg;
    logic        cfg_done = 1'b0;
    logic [1:0]  cfg_status = 2'b00;
    logic [31:0] cfg_rdata = '0;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, fwd_wdata;
    logic        mem_done = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hbx_bridge_xlate i_hbx_bridge_xlate (
        .clk(clk), .rst_n(rst_n), .ecam_sel(ecam_sel),
        .win_base(win_base), .win_limit(win_limit), .win_en(win_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_bus(cfg_bus),
        .cfg_dev(cfg_dev), .cfg_fn(cfg_fn), .cfg_reg(cfg_reg),
        .cfg_done(cfg_done), .cfg_status(cfg_status), .cfg_rdata(cfg_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .fwd_wdata(fwd_wdata), .mem_done(mem_done), .mem_err(mem_err),
        .mem_rdata(mem_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ecam_addr(input logic [7:0] b, input logic [4:0] d,
                                              input logic [2:0] f, input logic [11:0] r);
        return {4'h3, b, d, f, r};
    endfunction

    // Present one request for one edge; outputs of that edge are visible on return.
    task automatic send(input logic w, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_cfg(input logic [1:0] st, input logic [31:0] d);
        @(negedge clk);
        check("R10 ready low while waiting", req_ready, 0);
        cfg_done = 1'b1; cfg_status = st; cfg_rdata = d;
        @(negedge clk);
        cfg_done = 1'b0;
        check("R10 response strobe", rsp_valid, 1);
        check("R10 ready back", req_ready, 1);
    endtask

    task automatic finish_mem(input logic e, input logic [31:0] d);
        @(negedge clk);
        mem_done = 1'b1; mem_err = e; mem_rdata = d;
        @(negedge clk);
        mem_done = 1'b0;
        check("R10 mem response strobe", rsp_valid, 1);
    endtask

    task automatic t_reset;
        check("R10 reset ready", req_ready, 1);
        check("R10 reset rsp", rsp_valid, 0);
        check("R1 reset cfg_valid", cfg_valid, 0);
        check("R4 reset mem_valid", mem_valid, 0);
    endtask

    task automatic t_cfg_read_ok;
        send(1'b0, ecam_addr(8'h00, 5'd3, 3'd2, 12'h010), 32'h0);
        check("R1 cfg strobe", cfg_valid, 1);
        check("R1 cfg dir read", cfg_write, 0);
        check("R2 fields", {cfg_bus, cfg_dev, cfg_fn, cfg_reg}, {8'h00, 5'd3, 3'd2, 12'h010});
        check("R10 ready low", req_ready, 0);
        finish_cfg(2'b00, 32'h1234_5678);
        check("R9 cfg data", rsp_rdata, 32'h1234_5678);
        check("R9 cfg no err", rsp_err, 0);
        @(negedge clk);
        check("R10 single-cycle rsp", rsp_valid, 0);
    endtask

    task automatic t_cfg_write;
        send(1'b1, ecam_addr(8'hA5, 5'd31, 3'd7, 12'hFFC), 32'hCAFE_F00D);
        check("R1 cfg write dir", cfg_write, 1);
        check("R1 cfg wdata", fwd_wdata, 32'hCAFE_F00D);
        check("R2 fields max", {cfg_bus, cfg_dev, cfg_fn, cfg_reg}, {8'hA5, 5'd31, 3'd7, 12'hFFC});
        check("R4 no mem strobe", mem_valid, 0);
        finish_cfg(2'b00, 32'h0);
        check("R9 write ok", rsp_err, 0);
        send(1'b1, ecam_addr(8'h00, 5'd1, 3'd0, 12'h004), 32'h1);
        finish_cfg(2'b01, 32'h0);
        check("R8 failed write err", rsp_err, 1);
    endtask

    task automatic t_root_fail;
        send(1'b0, ecam_addr(8'h00, 5'd9, 3'd0, 12'h000), 32'h0);
        finish_cfg(2'b10, 32'h0000_0042);
        check("R6 nodev ones", rsp_rdata, 32'hFFFF_FFFF);
        check("R6 nodev no err", rsp_err, 0);
        send(1'b0, ecam_addr(8'h00, 5'd4, 3'd1, 12'h008), 32'h0);
        finish_cfg(2'b01, 32'h0000_0042);
        check("R7 UR ones", rsp_rdata, 32'hFFFF_FFFF);
        check("R7 UR no err", rsp_err, 0);
    endtask

    task automatic t_nonroot_fail;
        send(1'b0, ecam_addr(8'h02, 5'd0, 3'd0, 12'h000), 32'h0);
        check("R2 bus 2", cfg_bus, 8'h02);
        finish_cfg(2'b01, 32'h0);
        check("R8 nonroot ones", rsp_rdata, 32'hFFFF_FFFF);
        check("R8 nonroot err", rsp_err, 1);
    endtask

    task automatic t_window_edges;
        send(1'b0, 32'h4000_0000, 32'h0);
        check("R3 win0 base hit", mem_valid, 1);
        check("R4 addr same", mem_addr, 32'h4000_0000);
        check("R4 dir read", mem_write, 0);
        check("R1 no cfg strobe", cfg_valid, 0);
        finish_mem(1'b0, 32'hDEAD_BEEF);
        check("R9 mem data", rsp_rdata, 32'hDEAD_BEEF);
        check("R9 mem no err", rsp_err, 0);
        send(1'b1, 32'h8FFF_FFFC, 32'h5555_AAAA);
        check("R3 win1 limit hit", mem_valid, 1);
        check("R4 addr same w", mem_addr, 32'h8FFF_FFFC);
        check("R4 dir write", mem_write, 1);
        check("R4 wdata", fwd_wdata, 32'h5555_AAAA);
        finish_mem(1'b1, 32'h1111_1111);
        check("R9 mem err passthrough", rsp_err, 1);
        check("R9 write zero data", rsp_rdata, 32'h0);
        send(1'b0, 32'hC00F_FFFF, 32'h0);
        check("R3 win2 exact limit", mem_valid, 1);
        finish_mem(1'b0, 32'h7);
    endtask

    task automatic t_miss;
        send(1'b0, 32'h4001_0000, 32'h0);
        check("R5 miss rsp", rsp_valid, 1);
        check("R5 miss err", rsp_err, 1);
        check("R5 miss data", rsp_rdata, 32'h0);
        check("R5 no mem", mem_valid, 0);
        check("R5 no cfg", cfg_valid, 0);
        send(1'b1, 32'h2000_0000, 32'h9);
        check("R5 low miss err", {rsp_valid, rsp_err, mem_valid}, 3'b110);
        win_en = 3'b011;
        send(1'b0, 32'hC000_0000, 32'h0);
        check("R3 disabled window", {rsp_valid, rsp_err, mem_valid}, 3'b110);
        win_en = 3'b111;
    endtask

    task automatic t_precedence;
        win_base[31:0] = 32'h3000_0000;
        win_limit[31:0] = 32'h3FFF_FFFF;
        send(1'b0, ecam_addr(8'h00, 5'd0, 3'd0, 12'h000), 32'h0);
        check("R2 aperture first cfg", cfg_valid, 1);
        check("R2 aperture first mem", mem_valid, 0);
        finish_cfg(2'b00, 32'h8086_0000);
        win_base[31:0] = 32'h4000_0000;
        win_limit[31:0] = 32'h4000_FFFF;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        win_base  = {32'hC000_0000, 32'h8000_0000, 32'h4000_0000};
        win_limit = {32'hC00F_FFFF, 32'h8FFF_FFFF, 32'h4000_FFFF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_read_ok();
        t_cfg_write();
        t_root_fail();
        t_nonroot_fail();
        t_window_edges();
        t_miss();
        t_precedence();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule